// File: doc/BRIEF.md
# Clause-22 Management Frame Controller

This block runs one clause-22 management transaction at a time on the MDC/MDIO pins of an Ethernet PHY bus. The host side has three word-wide registers: a control word, a packed access word and a presence bitmap. Software writes the control word once to set the clock divider and turn the controller on. For each transaction it writes the access word with the go bit set, then polls that bit until the controller clears it. After a read, the PHY's 16-bit answer is in the low half of the same word.

The MDC clock is derived from the system clock by a programmable divider and stays low between frames. MDIO is driven through an output-enable pin, which is released for the turnaround and data phases of a read. Every read also records whether the addressed PHY drove the turnaround low. The result goes into a 32-bit bitmap with one bit per PHY address.

Register select: 0 is the control word, 1 is the access word, 2 is the presence bitmap, and 3 reads zero. In the control word, bit 31 reads 1 when no frame is in flight, bit 30 enables the controller, bit 20 set drops the preamble, and bits 7:0 hold the divider. In the access word, bit 31 is go/busy, bit 30 selects a write, bits 25:21 hold the register number, bits 20:16 the PHY address and bits 15:0 the data.

Top module: `mdio_host`

## Requirements
- R1: After reset the control word reads idle=1, enable=0, preamble-drop=0 and divider=RST_DIV (9 by default). The access word and the presence bitmap read zero, MDC is low and the MDIO output enable is low.
- R2: An access write with bit 31 set, made while enabled and idle, starts a frame. The access word reads busy=1 from the next cycle until the frame ends, and then reads busy=0, as does the control word's idle bit.
- R3: While enable (control bit 30) is 0, an access write with bit 31 set starts no frame. The fields are stored, busy stays 0 and MDC stays low.
- R4: An access write made while busy is ignored. The stored fields stay as they were and the running frame is unchanged.
- R5: While a frame runs, MDC has a period of 2*(divider+1) system clocks. MDC is low whenever the controller is idle.
- R6: A write frame drives, MSB first, 32 ones, then 01, then opcode 01, then the 5-bit PHY address, the 5-bit register number, turnaround 10 and the 16 data bits. The output enable stays high for all 64 bits.
- R7: With control bit 20 set, the 32 preamble ones are left out and the frame begins at the start code.
- R8: A read frame uses opcode 10. The controller drives MDIO up to the register number and releases the output enable for the two turnaround bits and the 16 data bits. It samples those 16 bits MSB first, and when the frame ends it places them in access bits 15:0.
- R9: A read sets the presence bit at the PHY's address when MDIO is low at the second turnaround bit, and clears that bit otherwise. Other bits of the bitmap are not changed.
- R10: MDIO and its output enable change only while MDC is low. Bits advance on MDC falling edges, and MDIO is sampled on rising edges.
- R11: An access write that lands in the same cycle a frame ends is ignored. The access word keeps the finished frame's fields and read data, and no new frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
Two events can fall in the same system cycle: the end of a frame, which clears busy and loads the read data, and a host write to the access word. The bench provokes this by starting a read and then writing a new go word on every cycle in which it still sees busy. One of these writes is then bound to land on the closing cycle. The test passes if the access word afterwards holds the original PHY and register fields and the PHY's answer, busy is clear, and MDC stays quiet, which shows that no second frame started.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int FRAME_LEN = 64;
   localparam int PRE_LEN   = 32;
   localparam int TA_POS    = 46;
   localparam int DATA_POS  = 48;
   localparam int AW        = 5;
   localparam int DW        = 16;
   localparam int NUM_PHY   = 1 << AW;

   localparam int ACC_GO    = 31;
   localparam int ACC_WR    = 30;
   localparam int ACC_REG   = 21;
   localparam int ACC_PHY   = 16;
   localparam int CTL_IDLE  = 31;
   localparam int CTL_EN    = 30;
   localparam int CTL_NOPRE = 20;

   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_ACC   = 2'd1,
      SEL_ALIVE = 2'd2,
      SEL_NONE  = 2'd3
   } reg_sel_e;

   function automatic logic [FRAME_LEN-1:0] build_frame(
      input logic          rd,
      input logic [AW-1:0] phy,
      input logic [AW-1:0] regad,
      input logic [DW-1:0] data);
      return {{PRE_LEN{1'b1}}, 2'b01, (rd ? 2'b10 : 2'b01), phy, regad,
              (rd ? 2'b11 : 2'b10), (rd ? {DW{1'b1}} : data)};
   endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             mdc,
   output logic             rise,
   output logic             fall
);
   logic [DIV_W-1:0] cnt_q;
   logic             mdc_q;
   logic             tick;

   assign tick = run && (cnt_q == div);
   assign rise = tick && !mdc_q;
   assign fall = tick && mdc_q;
   assign mdc  = mdc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (tick) begin
         cnt_q <= '0;
         mdc_q <= ~mdc_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
   import mdio_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          start_rd,
   input  logic [AW-1:0] start_phy,
   input  logic [AW-1:0] start_reg,
   input  logic [DW-1:0] start_data,
   input  logic          skip_pre,
   input  logic          rise,
   input  logic          fall,
   input  logic          mdio_i,
   output logic          active,
   output logic          mdio_o,
   output logic          mdio_oe,
   output logic          done,
   output logic [DW-1:0] rd_data,
   output logic          probe_ev,
   output logic [AW-1:0] probe_phy,
   output logic          probe_ok
);
   localparam logic [5:0] LAST   = 6'(FRAME_LEN - 1);
   localparam logic [5:0] TA2    = 6'(TA_POS + 1);
   localparam logic [5:0] TA1    = 6'(TA_POS);
   localparam logic [5:0] DFIRST = 6'(DATA_POS);

   logic                 act_q, rd_q;
   logic [5:0]           pos_q;
   logic [FRAME_LEN-1:0] frm_q;
   logic [AW-1:0]        phy_q;
   logic [DW-1:0]        shf_q;

   assign active  = act_q;
   assign done    = act_q && fall && (pos_q == LAST);
   assign mdio_o  = act_q ? frm_q[LAST - pos_q] : 1'b1;
   assign mdio_oe = act_q && !(rd_q && (pos_q >= TA1));
   assign rd_data = shf_q;

   assign probe_ev  = act_q && rd_q && rise && (pos_q == TA2);
   assign probe_phy = phy_q;
   assign probe_ok  = !mdio_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         rd_q  <= 1'b0;
         pos_q <= '0;
         frm_q <= '0;
         phy_q <= '0;
         shf_q <= '0;
      end else if (start && !act_q) begin
         act_q <= 1'b1;
         rd_q  <= start_rd;
         pos_q <= skip_pre ? 6'(PRE_LEN) : 6'd0;
         frm_q <= build_frame(start_rd, start_phy, start_reg, start_data);
         phy_q <= start_phy;
      end else if (act_q) begin
         if (rise && rd_q && (pos_q >= DFIRST))
            shf_q <= {shf_q[DW-2:0], mdio_i};
         if (fall) begin
            if (pos_q == LAST) act_q <= 1'b0;
            else               pos_q <= pos_q + 6'd1;
         end
      end
   end
endmodule

// File: rtl/mdio_alive_map.sv
module mdio_alive_map #(
   parameter int N     = 32,
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd,
   input  logic [IDX_W-1:0] idx,
   input  logic             val,
   output logic [N-1:0]     map
);
   for (genvar g = 0; g < N; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            map[g] <= 1'b0;
         else if (upd && (idx == IDX_W'(g)))
            map[g] <= val;
      end
   end
endmodule

// File: rtl/mdio_host.sv
module mdio_host
   import mdio_pkg::*;
#(
   parameter int DIV_W   = 8,
   parameter int RST_DIV = 9
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [1:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div_w
      $error("mdio_host: DIV_W must lie in 1..8");
   end
   if (RST_DIV < 0 || RST_DIV >= (1 << DIV_W)) begin : g_bad_rst_div
      $error("mdio_host: RST_DIV does not fit DIV_W");
   end

   logic             en_q, nopre_q, busy_q, wr_q;
   logic [DIV_W-1:0] div_q;
   logic [AW-1:0]    reg_q, phy_q;
   logic [DW-1:0]    data_q;

   logic             acc_wr, ctl_wr, go;
   logic             rise, fall, active, done;
   logic [DW-1:0]    rd_data;
   logic             probe_ev, probe_ok;
   logic [AW-1:0]    probe_phy;
   logic [NUM_PHY-1:0] alive;
   logic [7:0]       div8;

   assign acc_wr = reg_wr && (reg_sel_e'(reg_addr) == SEL_ACC);
   assign ctl_wr = reg_wr && (reg_sel_e'(reg_addr) == SEL_CTRL);
   assign go     = acc_wr && !busy_q && reg_wdata[ACC_GO] && en_q;
   assign div8   = 8'(div_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         nopre_q <= 1'b0;
         div_q   <= DIV_W'(RST_DIV);
      end else if (ctl_wr) begin
         en_q    <= reg_wdata[CTL_EN];
         nopre_q <= reg_wdata[CTL_NOPRE];
         div_q   <= reg_wdata[DIV_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         wr_q   <= 1'b0;
         reg_q  <= '0;
         phy_q  <= '0;
         data_q <= '0;
      end else if (done) begin
         busy_q <= 1'b0;
         if (!wr_q) data_q <= rd_data;
      end else if (acc_wr && !busy_q) begin
         busy_q <= go;
         wr_q   <= reg_wdata[ACC_WR];
         reg_q  <= reg_wdata[ACC_REG +: AW];
         phy_q  <= reg_wdata[ACC_PHY +: AW];
         data_q <= reg_wdata[DW-1:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_sel_e'(reg_addr))
         SEL_CTRL: begin
            reg_rdata[CTL_IDLE]  = !busy_q;
            reg_rdata[CTL_EN]    = en_q;
            reg_rdata[CTL_NOPRE] = nopre_q;
            reg_rdata[7:0]       = div8;
         end
         SEL_ACC: begin
            reg_rdata[ACC_GO]          = busy_q;
            reg_rdata[ACC_WR]          = wr_q;
            reg_rdata[ACC_REG +: AW]   = reg_q;
            reg_rdata[ACC_PHY +: AW]   = phy_q;
            reg_rdata[DW-1:0]          = data_q;
         end
         SEL_ALIVE: reg_rdata = alive;
         default:   reg_rdata = '0;
      endcase
   end

   mdio_clkgen #(.DIV_W(DIV_W)) i_clkgen (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (active),
      .div   (div_q),
      .mdc   (mdc),
      .rise  (rise),
      .fall  (fall)
   );

   mdio_frame_engine i_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (go),
      .start_rd   (!reg_wdata[ACC_WR]),
      .start_phy  (reg_wdata[ACC_PHY +: AW]),
      .start_reg  (reg_wdata[ACC_REG +: AW]),
      .start_data (reg_wdata[DW-1:0]),
      .skip_pre   (nopre_q),
      .rise       (rise),
      .fall       (fall),
      .mdio_i     (mdio_i),
      .active     (active),
      .mdio_o     (mdio_o),
      .mdio_oe    (mdio_oe),
      .done       (done),
      .rd_data    (rd_data),
      .probe_ev   (probe_ev),
      .probe_phy  (probe_phy),
      .probe_ok   (probe_ok)
   );

   mdio_alive_map #(.N(NUM_PHY), .IDX_W(AW)) i_alive (
      .clk   (clk),
      .rst_n (rst_n),
      .upd   (probe_ev),
      .idx   (probe_phy),
      .val   (probe_ok),
      .map   (alive)
   );
endmodule

// File: rtl/mdio_host_chk.sv
module mdio_host_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       mdc,
   input logic       mdio_o,
   input logic       mdio_oe,
   input logic       busy,
   input logic       en,
   input logic       wr,
   input logic [4:0] phy,
   input logic [4:0] regad
);
   // R5: no clock activity while idle
   p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe));

   // R10: pin values change only while MDC is low
   p_mdio_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

   // R4: fields are frozen while a frame runs
   p_fields_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && busy) |-> ($stable(phy) && $stable(regad) && $stable(wr)));

   // R8: the enable is dropped mid-frame only for reads
   p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(mdio_oe) && busy) |-> !wr);

   // R3: nothing starts while disabled
   p_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !busy) |=> !busy);
endmodule

bind mdio_host mdio_host_chk i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .mdc     (mdc),
   .mdio_o  (mdio_o),
   .mdio_oe (mdio_oe),
   .busy    (busy_q),
   .en      (en_q),
   .wr      (wr_q),
   .phy     (phy_q),
   .regad   (reg_q)
);

// File: tb/test_mdio_host.sv
module test_mdio_host;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i;

   int checks = 0;
   int fails = 0;
   bit finished = 0;

   bit          expect_read = 0;
   bit          phy_present = 0;
   logic [15:0] phy_data = '0;

   logic [63:0] cap = '0;
   int          ncap = 0;
   int          cyc = 0;
   int          last_rise = 0;
   int          period = 0;

   mdio_host i_mdio_host (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc++;
   always @(posedge mdc) begin
      period = cyc - last_rise;
      last_rise = cyc;
      if (mdio_oe) begin
         cap = {cap[62:0], mdio_o};
         ncap++;
      end
   end

   // PHY model: answers reads after the controller releases MDIO
   initial begin
      mdio_i = 1'b1;
      forever begin
         @(negedge mdio_oe);
         if (rst_n && expect_read) begin
            @(negedge mdc);
            mdio_i = phy_present ? 1'b0 : 1'b1;
            for (int k = 15; k >= 0; k--) begin
               @(negedge mdc);
               mdio_i = phy_present ? phy_data[k] : 1'b1;
            end
            @(negedge mdc);
            mdio_i = 1'b1;
         end
      end
   end

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 5000; i++) begin
         rd_reg(2'd1, v);
         if (!v[31]) return;
      end
      check(0, "R2 frame never ended", 1, 0);
   endtask

   function automatic logic [31:0] acc(input bit go, input bit w, input int r,
                                       input int p, input logic [15:0] d);
      return {go, w, 4'b0, 5'(r), 5'(p), d};
   endfunction

   task automatic t_reset();
      logic [31:0] v;
      rd_reg(2'd0, v); check(v == 32'h8000_0009, "R1 control after reset", v, 32'h8000_0009);
      rd_reg(2'd1, v); check(v == 0, "R1 access after reset", v, 0);
      rd_reg(2'd2, v); check(v == 0, "R1 alive after reset", v, 0);
      check(mdc == 0 && mdio_oe == 0, "R1 pins after reset", {mdc, mdio_oe}, 0);
   endtask

   task automatic t_disabled();
      logic [31:0] v;
      int n0;
      n0 = ncap;
      wr_reg(2'd1, acc(1, 1, 2, 6, 16'hBEEF));
      repeat (20) @(negedge clk);
      rd_reg(2'd1, v);
      check(v == acc(0, 1, 2, 6, 16'hBEEF), "R3 go while disabled", v, acc(0, 1, 2, 6, 16'hBEEF));
      check(ncap == n0 && mdc == 0, "R3 no MDC while disabled", ncap - n0, 0);
   endtask

   task automatic t_write();
      logic [31:0] v, exp;
      wr_reg(2'd0, 32'h4000_0001);
      ncap = 0;
      wr_reg(2'd1, acc(1, 1, 5, 3, 16'hA5C3));
      rd_reg(2'd1, v); check(v[31] == 1, "R2 busy after go", v[31], 1);
      rd_reg(2'd0, v); check(v[31] == 0, "R2 idle bit low while busy", v[31], 0);
      wait_idle();
      exp = {2'b01, 2'b01, 5'd3, 5'd5, 2'b10, 16'hA5C3};
      check(ncap == 64, "R6 write frame length", ncap, 64);
      check(cap == {32'hFFFF_FFFF, exp}, "R6 write frame bits", cap, {32'hFFFF_FFFF, exp});
      check(period == 4, "R5 MDC period div=1", period, 4);
      rd_reg(2'd0, v); check(v[31] == 1, "R2 idle after frame", v[31], 1);
   endtask

   task automatic t_busy_ignore();
      logic [31:0] v, exp;
      ncap = 0;
      wr_reg(2'd1, acc(1, 1, 9, 1, 16'h0F0F));
      repeat (6) @(negedge clk);
      wr_reg(2'd1, acc(1, 1, 17, 30, 16'h1111));
      wait_idle();
      exp = {2'b01, 2'b01, 5'd1, 5'd9, 2'b10, 16'h0F0F};
      check(cap[31:0] == exp && ncap == 64, "R4 frame unchanged by busy write", cap[31:0], exp);
      rd_reg(2'd1, v);
      check(v == acc(0, 1, 9, 1, 16'h0F0F), "R4 fields kept", v, acc(0, 1, 9, 1, 16'h0F0F));
   endtask

   task automatic t_read(input int p, input int r, input bit present,
                         input logic [15:0] d, input int div);
      logic [31:0] v;
      logic [15:0] expd;
      wr_reg(2'd0, 32'h4000_0000 | 32'(div));
      expect_read = 1; phy_present = present; phy_data = d;
      ncap = 0;
      wr_reg(2'd1, acc(1, 0, r, p, 16'h0));
      wait_idle();
      expect_read = 0;
      expd = present ? d : 16'hFFFF;
      rd_reg(2'd1, v);
      check(v == acc(0, 0, r, p, expd), "R8 read result", v, acc(0, 0, r, p, expd));
      check(ncap == 46 && cap[13:0] == {2'b01, 2'b10, 5'(p), 5'(r)},
            "R8 read header", {ncap[7:0], cap[13:0]}, {8'd46, 2'b01, 2'b10, 5'(p), 5'(r)});
      check(period == 2 * (div + 1), "R5 MDC period", period, 2 * (div + 1));
      rd_reg(2'd2, v);
      check(v[p] == present, "R9 alive bit", v[p], present);
   endtask

   task automatic t_alive_map();
      logic [31:0] v;
      t_read(7, 2, 1, 16'h1234, 2);
      t_read(4, 1, 1, 16'h8001, 1);
      t_read(7, 3, 0, 16'h0000, 1);
      rd_reg(2'd2, v);
      check(v == 32'h0000_0010, "R9 alive map after set and clear", v, 32'h10);
   endtask

   task automatic t_nopre();
      logic [31:0] exp;
      wr_reg(2'd0, 32'h4010_0001);
      ncap = 0;
      wr_reg(2'd1, acc(1, 1, 31, 31, 16'h7E81));
      wait_idle();
      exp = {2'b01, 2'b01, 5'd31, 5'd31, 2'b10, 16'h7E81};
      check(ncap == 32 && cap[31:0] == exp, "R7 frame without preamble", cap[31:0], exp);
      wr_reg(2'd0, 32'h4000_0001);
   endtask

   task automatic t_collide();
      logic [31:0] v;
      int n0;
      expect_read = 1; phy_present = 1; phy_data = 16'hC0DE;
      wr_reg(2'd1, acc(1, 0, 12, 21, 16'h0));
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         reg_addr = 2'd1;
         #1;
         if (reg_rdata[31]) begin
            reg_wdata = acc(1, 1, 3, 3, 16'h5555);
            reg_wr = 1'b1;
         end else begin
            reg_wr = 1'b0;
            break;
         end
      end
      reg_wr = 1'b0;
      expect_read = 0;
      n0 = ncap;
      repeat (40) @(negedge clk);
      rd_reg(2'd1, v);
      check(v == acc(0, 0, 12, 21, 16'hC0DE), "R11 write at frame end ignored", v,
            acc(0, 0, 12, 21, 16'hC0DE));
      check(ncap == n0 && mdc == 0, "R11 no new frame", ncap - n0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_disabled();
      t_write();
      t_busy_ignore();
      t_alive_map();
      t_nopre();
      t_collide();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         finished = 1;
         checks++; fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule